// File: doc/BRIEF.md
# Event Timer Main Counter and Register Decoder

This block keeps the free-running 64-bit main counter of a multi-channel event timer, together with the global capability and configuration registers. It also decodes the memory-mapped register window that software uses. Every access is 4 or 8 bytes wide. A 64-bit register is reached whole with an aligned 8-byte access, or in 32-bit halves, where address bit 2 picks the upper half. Accesses that fall in the per-channel window are not served here. They are turned into decoded strobes, with a channel index and a field select, for the comparator channels that sit beside this block. Those channels return their register value on `ch_rdata`, and this block slices it.

The counter advances by one every clock while the global enable bit is set. It freezes when that bit is cleared, and software may overwrite it at any moment. A small sequencer watches the enable bit. Each 0-to-1 change gives a one-cycle pulse that tells every channel to re-arm and to re-raise its pending lines. Each 1-to-0 change gives a one-cycle halt pulse. The sequencer has four states. HALTED is left for ARMING when the enable is seen set. ARMING goes on to RUNNING, or to HALTING if the enable has already dropped. RUNNING goes to HALTING when the enable is seen clear. HALTING returns to HALTED, or to ARMING if the enable is set again. `rearm_pulse` is high only in ARMING and `halt_pulse` is high only in HALTING.

Top module: `evtmr_core_regs`

## Requirements
- R1: After reset the main counter is 0, the configuration register is 0, `enable`, `legacy_route`, `rearm_pulse`, `halt_pulse` and `bus_rvalid` are low.
- R2: The capability register at offset 0x000 reads, in its low word, 0x8086 in bits 31:16, 3'b101 in bits 15:13, NCH-1 in bits 12:8 and 0x01 in bits 7:0 (0x8086A201 for NCH=3). Its high word reads the tick period in femtoseconds (TICK_FS). Writes to it change nothing.
- R3: While configuration bit 0 is 1, the counter at offset 0x0F0 grows by exactly 1 per clock, and the carry crosses from the low half into the high half. While bit 0 is 0 the counter holds. A read returns the value held in the cycle the request is taken.
- R4: The counter can be written whether enabled or not. An 8-byte write replaces it. A 4-byte write replaces only the half that address bit 2 selects. In the write cycle the written value replaces the increment, and counting resumes from it.
- R5: The configuration register at offset 0x010 has bit 0 as the enable and bit 1 as legacy routing, driven on `enable` and `legacy_route`. All other bits read 0, and writes to them, including any 4-byte write to the high half, have no effect.
- R6: One cycle after the configuration register's enable bit goes from 0 to 1, `rearm_pulse` is high for one cycle. One cycle after it goes from 1 to 0, `halt_pulse` is high for one cycle. The two are never high together.
- R7: `bus_rvalid` is high in the cycle after a read request and low after a write. A 4-byte read returns the selected half in bits 31:0, with bits 63:32 zero. An 8-byte read returns the whole register.
- R8: Unmapped global offsets read 0 and ignore writes. So does an access with address bits 1:0 nonzero, or an 8-byte access with address bit 2 set.
- R9: Offset 0x100 + 0x20*n addresses channel n, and address bits 4:3 select the field (0 configuration, 1 comparator, 2 route). For such an access, `ch_wr` or `ch_rd` is high in the same cycle, with `ch_idx`=n, `ch_field`, `ch_hi`, `ch_wide` and `ch_wdata`. A read returns `ch_rdata`, sliced as in R7. Field value 3 is unmapped.
- R10: Channel slots n >= NCH raise no strobe, read 0 and ignore writes.
- R11: The status register at offset 0x020 reads `ch_status` in its low NCH bits. A write to its low word drives `status_clr` = written bits AND `ch_status` in the same cycle. A high-half write clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Byte offset in the register window |
| bus_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| bus_wdata | input | 64 | Write data (4-byte data in bits 31:0) |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 64 | Read data |
| ch_wr | output | 1 | Channel register write strobe |
| ch_rd | output | 1 | Channel register read strobe |
| ch_idx | output | CH_IDX_W | Addressed channel |
| ch_field | output | 2 | Channel field select (0 config, 1 comparator, 2 route) |
| ch_hi | output | 1 | Upper-half select for 4-byte channel access |
| ch_wide | output | 1 | 8-byte channel access |
| ch_wdata | output | 64 | Channel write data |
| ch_rdata | input | 64 | Full 64-bit value of the addressed channel field |
| ch_status | input | NCH | Pending status of every channel |
| status_clr | output | NCH | Per-channel status clear strobes |
| main_count | output | 64 | Current main counter value |
| enable | output | 1 | Global enable (configuration bit 0) |
| legacy_route | output | 1 | Legacy routing select (configuration bit 1) |
| rearm_pulse | output | 1 | One-cycle pulse after the enable rises |
| halt_pulse | output | 1 | One-cycle pulse after the enable falls |

## Verification
The counter's own increment and a software write to the counter can land on the same clock edge. This happens whenever software writes the counter while the enable is set. The bench provokes it by running the counter across a 32-bit carry and then writing only the low half mid-count. The following whole-register read must return exactly the new low half joined to the untouched high half, with no extra increment. The read after that must be one higher. The sequencer cases are judged the same way: a rising or falling enable edge must show its pulse exactly one cycle after the configuration write, while the counter keeps or stops counting on the very next edge.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

    typedef enum logic [1:0] {
        EN_HALTED,
        EN_ARMING,
        EN_RUNNING,
        EN_HALTING
    } en_state_t;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CAP,
        RG_CFG,
        RG_STAT,
        RG_CNT,
        RG_CHAN
    } region_t;

    // Global register slots, counted in 8-byte words (address bits 7:3)
    localparam logic [4:0] SLOT_CAP  = 5'd0;
    localparam logic [4:0] SLOT_CFG  = 5'd2;
    localparam logic [4:0] SLOT_STAT = 5'd4;
    localparam logic [4:0] SLOT_CNT  = 5'd30;

    // First channel window, in 32-byte units (address bits 10:5)
    localparam logic [5:0] CHAN_BASE = 6'd8;

    localparam logic [1:0] FLD_UNMAPPED = 2'd3;

    function automatic logic [63:0] merge_half(input logic [63:0] old_v,
                                               input logic [63:0] wd,
                                               input logic        hi,
                                               input logic        wide);
        if (wide)
            return wd;
        else if (hi)
            return {wd[31:0], old_v[31:0]};
        else
            return {old_v[63:32], wd[31:0]};
    endfunction

    function automatic logic [63:0] read_half(input logic [63:0] v,
                                              input logic        hi,
                                              input logic        wide);
        if (wide)
            return v;
        else if (hi)
            return {32'h0, v[63:32]};
        else
            return {32'h0, v[31:0]};
    endfunction

endpackage

// File: rtl/evtmr_addr_decode.sv
module evtmr_addr_decode
    import evtmr_pkg::*;
#(
    parameter int NCH      = 3,
    parameter int ADDR_W   = 11,
    parameter int CH_IDX_W = 2
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wide,
    output region_t             region,
    output logic [CH_IDX_W-1:0] chan,
    output logic [1:0]          field,
    output logic                hi
);
    logic       misaligned;
    logic       global_area;
    logic [5:0] slot;

    assign misaligned  = (addr[1:0] != 2'b00) || (wide && addr[2]);
    assign global_area = (addr[ADDR_W-1:8] == '0);
    assign slot        = addr[10:5] - CHAN_BASE;
    assign chan        = slot[CH_IDX_W-1:0];
    assign field       = addr[4:3];
    assign hi          = addr[2];

    always_comb begin
        region = RG_NONE;
        if (!misaligned) begin
            if (global_area) begin
                unique case (addr[7:3])
                    SLOT_CAP:  region = RG_CAP;
                    SLOT_CFG:  region = RG_CFG;
                    SLOT_STAT: region = RG_STAT;
                    SLOT_CNT:  region = RG_CNT;
                    default:   region = RG_NONE;
                endcase
            end else if ((slot < 6'(NCH)) && (addr[4:3] != FLD_UNMAPPED)) begin
                region = RG_CHAN;
            end
        end
    end

endmodule

// File: rtl/evtmr_main_counter.sv
module evtmr_main_counter
    import evtmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr_en,
    input  logic             wr_hi,
    input  logic             wr_wide,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (wr_en)
            count_q <= merge_half(count_q, wr_data, wr_hi, wr_wide);
        else if (run)
            count_q <= count_q + CNT_W'(1);
    end

    assign count = count_q;

endmodule

// File: rtl/evtmr_enable_seq.sv
module evtmr_enable_seq
    import evtmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_bit,
    output logic rearm,
    output logic halt
);
    en_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= EN_HALTED;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EN_HALTED:  state_d = en_bit ? EN_ARMING  : EN_HALTED;
            EN_ARMING:  state_d = en_bit ? EN_RUNNING : EN_HALTING;
            EN_RUNNING: state_d = en_bit ? EN_RUNNING : EN_HALTING;
            EN_HALTING: state_d = en_bit ? EN_ARMING  : EN_HALTED;
            default:    state_d = EN_HALTED;
        endcase
    end

    always_comb begin
        rearm = 1'b0;
        halt  = 1'b0;
        unique case (state_q)
            EN_ARMING:  rearm = 1'b1;
            EN_HALTING: halt  = 1'b1;
            default: begin
                rearm = 1'b0;
                halt  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/evtmr_core_regs.sv
module evtmr_core_regs
    import evtmr_pkg::*;
#(
    parameter int           NCH     = 3,
    parameter logic [31:0]  TICK_FS = 32'd10_000_000,
    localparam int          ADDR_W  = 11,
    localparam int          CNT_W   = 64,
    localparam int          CH_IDX_W = $clog2(NCH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wide,
    input  logic [63:0]         bus_wdata,
    output logic                bus_rvalid,
    output logic [63:0]         bus_rdata,
    output logic                ch_wr,
    output logic                ch_rd,
    output logic [CH_IDX_W-1:0] ch_idx,
    output logic [1:0]          ch_field,
    output logic                ch_hi,
    output logic                ch_wide,
    output logic [63:0]         ch_wdata,
    input  logic [63:0]         ch_rdata,
    input  logic [NCH-1:0]      ch_status,
    output logic [NCH-1:0]      status_clr,
    output logic [CNT_W-1:0]    main_count,
    output logic                enable,
    output logic                legacy_route,
    output logic                rearm_pulse,
    output logic                halt_pulse
);
    localparam logic [4:0]  NUM_FIELD = 5'(NCH - 1);
    localparam logic [63:0] CAP_WORD  = {TICK_FS, 16'h8086, 3'b101, NUM_FIELD, 8'h01};

    region_t             region;
    logic [CH_IDX_W-1:0] dec_chan;
    logic [1:0]          dec_field;
    logic                dec_hi;
    logic                do_wr, do_rd, low_touched;
    logic [1:0]          cfg_q;
    logic [63:0]         rd_full;

    evtmr_addr_decode #(
        .NCH     (NCH),
        .ADDR_W  (ADDR_W),
        .CH_IDX_W(CH_IDX_W)
    ) u_decode (
        .addr  (bus_addr),
        .wide  (bus_wide),
        .region(region),
        .chan  (dec_chan),
        .field (dec_field),
        .hi    (dec_hi)
    );

    assign do_wr       = bus_req && bus_wr;
    assign do_rd       = bus_req && !bus_wr;
    assign low_touched = bus_wide || !dec_hi;

    evtmr_main_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cfg_q[0]),
        .wr_en  (do_wr && (region == RG_CNT)),
        .wr_hi  (dec_hi),
        .wr_wide(bus_wide),
        .wr_data(bus_wdata),
        .count  (main_count)
    );

    evtmr_enable_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .en_bit(cfg_q[0]),
        .rearm (rearm_pulse),
        .halt  (halt_pulse)
    );

    // Global configuration: only enable and legacy routing are writable
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= 2'b00;
        else if (do_wr && (region == RG_CFG) && low_touched)
            cfg_q <= bus_wdata[1:0];
    end

    assign enable       = cfg_q[0];
    assign legacy_route = cfg_q[1];

    assign status_clr = (do_wr && (region == RG_STAT) && low_touched)
                        ? (bus_wdata[NCH-1:0] & ch_status) : '0;

    // Channel strobes, same cycle as the request
    assign ch_wr    = do_wr && (region == RG_CHAN);
    assign ch_rd    = do_rd && (region == RG_CHAN);
    assign ch_idx   = dec_chan;
    assign ch_field = dec_field;
    assign ch_hi    = dec_hi;
    assign ch_wide  = bus_wide;
    assign ch_wdata = bus_wdata;

    always_comb begin
        unique case (region)
            RG_CAP:  rd_full = CAP_WORD;
            RG_CFG:  rd_full = {62'h0, cfg_q};
            RG_STAT: rd_full = {{(64-NCH){1'b0}}, ch_status};
            RG_CNT:  rd_full = main_count;
            RG_CHAN: rd_full = ch_rdata;
            default: rd_full = 64'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= 64'h0;
        end else begin
            bus_rvalid <= do_rd;
            if (do_rd)
                bus_rdata <= read_half(rd_full, dec_hi, bus_wide);
        end
    end

endmodule

// File: rtl/evtmr_core_regs_sva.sv
module evtmr_core_regs_sva #(
    parameter int NCH = 3,
    parameter int CH_IDX_W = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_req,
    input logic                bus_wr,
    input logic [10:0]         bus_addr,
    input logic                bus_wide,
    input logic                bus_rvalid,
    input logic                ch_wr,
    input logic                ch_rd,
    input logic [CH_IDX_W-1:0] ch_idx,
    input logic [63:0]         main_count,
    input logic                enable,
    input logic                legacy_route,
    input logic                rearm_pulse,
    input logic                halt_pulse
);
    logic aligned, cnt_write, cfg_write;

    assign aligned   = (bus_addr[1:0] == 2'b00) && !(bus_wide && bus_addr[2]);
    assign cnt_write = bus_req && bus_wr && aligned && (bus_addr[10:3] == 8'h1E);
    assign cfg_write = bus_req && bus_wr && aligned && (bus_addr[10:3] == 8'h02);

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !cnt_write) |=> (main_count == $past(main_count))); // R3

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !cnt_write) |=> (main_count == $past(main_count) + 64'd1)); // R3

    AST_REARM_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |=> rearm_pulse); // R6

    AST_HALT_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enable) |=> halt_pulse); // R6

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rearm_pulse && halt_pulse)); // R6

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_write |=> ($stable(enable) && $stable(legacy_route))); // R5

    AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_wr) |=> bus_rvalid); // R7

    AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_wr || ch_rd) |-> (32'(ch_idx) < NCH)); // R10

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ch_wr, ch_rd})); // R9

endmodule

bind evtmr_core_regs evtmr_core_regs_sva #(
    .NCH     (NCH),
    .CH_IDX_W(CH_IDX_W)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wide    (bus_wide),
    .bus_rvalid  (bus_rvalid),
    .ch_wr       (ch_wr),
    .ch_rd       (ch_rd),
    .ch_idx      (ch_idx),
    .main_count  (main_count),
    .enable      (enable),
    .legacy_route(legacy_route),
    .rearm_pulse (rearm_pulse),
    .halt_pulse  (halt_pulse)
);

// File: tb/tb_evtmr_core_regs.sv
`timescale 1ns/1ps
module tb_evtmr_core_regs;
    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [63:0] bus_rdata;
    logic        ch_wr, ch_rd, ch_hi, ch_wide;
    logic [1:0]  ch_idx;
    logic [1:0]  ch_field;
    logic [63:0] ch_wdata;
    logic [63:0] ch_rdata = '0;
    logic [NCH-1:0] ch_status = '0;
    logic [NCH-1:0] status_clr;
    logic [63:0] main_count;
    logic        enable, legacy_route, rearm_pulse, halt_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // values captured by bus_op
    logic        c_wr, c_rd, c_hi, c_wide, c_rvalid;
    logic [1:0]  c_idx, c_field;
    logic [NCH-1:0] c_clr;
    logic [63:0] c_rdata;

    always #5 clk = ~clk;

    evtmr_core_regs #(.NCH(NCH), .TICK_FS(32'd10_000_000)) dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wide(bus_wide),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .ch_wr(ch_wr), .ch_rd(ch_rd), .ch_idx(ch_idx), .ch_field(ch_field),
        .ch_hi(ch_hi), .ch_wide(ch_wide), .ch_wdata(ch_wdata), .ch_rdata(ch_rdata),
        .ch_status(ch_status), .status_clr(status_clr), .main_count(main_count),
        .enable(enable), .legacy_route(legacy_route),
        .rearm_pulse(rearm_pulse), .halt_pulse(halt_pulse)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // One request on one clock edge; called at a falling edge
    task automatic bus_op(input logic wr, input logic wide, input logic [10:0] addr,
                          input logic [63:0] wd);
        bus_req = 1'b1; bus_wr = wr; bus_wide = wide; bus_addr = addr; bus_wdata = wd;
        #1;
        c_wr = ch_wr; c_rd = ch_rd; c_idx = ch_idx; c_field = ch_field;
        c_hi = ch_hi; c_wide = ch_wide; c_clr = status_clr;
        @(posedge clk); #1;
        c_rvalid = bus_rvalid; c_rdata = bus_rdata;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0; bus_wide = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic idle_edge();
        @(posedge clk); #1;
    endtask

    typedef struct packed {
        logic        wr;
        logic        wide;
        logic [10:0] addr;
        logic [63:0] wd;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b0, 11'h000, 64'h0, 64'h0000_0000_8086_A201},            // R2 cap low
        '{1'b0, 1'b0, 11'h004, 64'h0, 64'h0000_0000_0098_9680},            // R2 cap high
        '{1'b0, 1'b1, 11'h000, 64'h0, 64'h0098_9680_8086_A201},            // R2 R7 cap whole
        '{1'b1, 1'b1, 11'h000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},            // R2 write ignored
        '{1'b0, 1'b1, 11'h000, 64'h0, 64'h0098_9680_8086_A201},            // R2 unchanged
        '{1'b1, 1'b0, 11'h010, 64'h0000_0000_FFFF_FFFE, 64'h0},            // R5 legacy only
        '{1'b0, 1'b1, 11'h010, 64'h0, 64'h2},                              // R5
        '{1'b1, 1'b0, 11'h014, 64'h0000_0000_FFFF_FFFF, 64'h0},            // R5 high half
        '{1'b0, 1'b1, 11'h010, 64'h0, 64'h2},                              // R5
        '{1'b0, 1'b1, 11'h008, 64'h0, 64'h0},                              // R8 unmapped
        '{1'b0, 1'b0, 11'h030, 64'h0, 64'h0},                              // R8 unmapped
        '{1'b1, 1'b0, 11'h0F1, 64'h5, 64'h0},                              // R8 misaligned
        '{1'b1, 1'b1, 11'h0F4, 64'h7, 64'h0},                              // R8 wide at bit 2
        '{1'b0, 1'b1, 11'h0F0, 64'h0, 64'h0},                              // R8 R3 counter still 0
        '{1'b1, 1'b0, 11'h010, 64'h0, 64'h0},                              // R5 clear
        '{1'b0, 1'b1, 11'h010, 64'h0, 64'h0}                               // R5
    };

    localparam logic [63:0] W0 = 64'h0000_0001_FFFF_FFFE;

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 counter", main_count, 64'h0);
        chk("R1 enable/legacy", {62'h0, enable, legacy_route}, 64'h0);
        chk("R1 pulses/rvalid", {61'h0, rearm_pulse, halt_pulse, bus_rvalid}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            bus_op(VT[i].wr, VT[i].wide, VT[i].addr, VT[i].wd);
            checks++;
            if (!VT[i].wr && c_rdata !== VT[i].exp) begin
                failures++;
                $display("FAIL vector %0d (R2/R5/R8) actual=0x%0h expected=0x%0h",
                         i, c_rdata, VT[i].exp);
            end
            chk("R7 rvalid per vector", {63'h0, c_rvalid}, {63'h0, !VT[i].wr});
            if (i == 6) chk("R5 legacy_route", {63'h0, legacy_route}, 64'h1);
            if (i == 6) chk("R5 enable stays 0", {63'h0, enable}, 64'h0);
        end

        // R4 whole write while halted, then R3 counting across the carry
        bus_op(1'b1, 1'b1, 11'h0F0, W0);
        bus_op(1'b0, 1'b1, 11'h0F0, 64'h0);
        chk("R4 wide write", c_rdata, W0);
        bus_op(1'b1, 1'b0, 11'h010, 64'h1);                 // enable at edge E0
        chk("R5 enable high", {63'h0, enable}, 64'h1);
        idle_edge();                                        // E1
        chk("R6 rearm pulse", {62'h0, rearm_pulse, halt_pulse}, 64'h2);
        @(negedge clk);
        bus_op(1'b0, 1'b0, 11'h0F0, 64'h0);                 // E2
        chk("R3 low half count", c_rdata, 64'hFFFF_FFFF);
        chk("R6 rearm one cycle", {63'h0, rearm_pulse}, 64'h0);
        bus_op(1'b0, 1'b0, 11'h0F4, 64'h0);                 // E3
        chk("R3 R7 carry into high half", c_rdata, 64'h2);
        bus_op(1'b0, 1'b1, 11'h0F0, 64'h0);                 // E4
        chk("R3 whole count", c_rdata, 64'h0000_0002_0000_0001);
        // R4 low-half write while running, coincides with an increment
        bus_op(1'b1, 1'b0, 11'h0F0, 64'hABCD_0000_0000_0010); // E5
        bus_op(1'b0, 1'b1, 11'h0F0, 64'h0);                 // E6
        chk("R4 half write while running", c_rdata, 64'h0000_0002_0000_0010);
        bus_op(1'b0, 1'b1, 11'h0F0, 64'h0);                 // E7
        chk("R4 count resumes", c_rdata, 64'h0000_0002_0000_0011);
        bus_op(1'b1, 1'b0, 11'h010, 64'h0);                 // E8 disable
        idle_edge();                                        // E9
        chk("R6 halt pulse", {62'h0, rearm_pulse, halt_pulse}, 64'h1);
        @(negedge clk);
        bus_op(1'b0, 1'b1, 11'h0F0, 64'h0);
        chk("R3 frozen", c_rdata, 64'h0000_0002_0000_0013);
        chk("R6 halt one cycle", {63'h0, halt_pulse}, 64'h0);
        bus_op(1'b0, 1'b1, 11'h0F0, 64'h0);
        chk("R3 still frozen", c_rdata, 64'h0000_0002_0000_0013);
        bus_op(1'b1, 1'b0, 11'h0F4, 64'h0000_0000_0000_0009);
        bus_op(1'b0, 1'b1, 11'h0F0, 64'h0);
        chk("R4 high half write", c_rdata, 64'h0000_0009_0000_0013);

        // R9 channel accesses
        ch_rdata = 64'h1122_3344_5566_7788;
        bus_op(1'b0, 1'b0, 11'h14C, 64'h0);
        chk("R9 read strobe", {59'h0, c_rd, c_wr, c_idx, c_hi}, {59'h0, 1'b1, 1'b0, 2'd2, 1'b1});
        chk("R9 field comparator", {62'h0, c_field}, 64'h1);
        chk("R9 R7 sliced read", c_rdata, 64'h1122_3344);
        bus_op(1'b1, 1'b1, 11'h130, 64'h55);
        chk("R9 write strobe", {58'h0, c_wr, c_rd, c_idx, c_field}, {58'h0, 1'b1, 1'b0, 2'd1, 2'd2});
        chk("R9 wide flag", {63'h0, c_wide}, 64'h1);
        bus_op(1'b0, 1'b1, 11'h100, 64'h0);
        chk("R9 whole channel read", c_rdata, 64'h1122_3344_5566_7788);
        bus_op(1'b0, 1'b1, 11'h118, 64'h0);
        chk("R9 field 3 unmapped", {62'h0, c_rd, c_wr}, 64'h0);
        chk("R9 field 3 reads zero", c_rdata, 64'h0);
        // R10 slot beyond NCH
        bus_op(1'b0, 1'b1, 11'h160, 64'h0);
        chk("R10 no read strobe", {63'h0, c_rd}, 64'h0);
        chk("R10 reads zero", c_rdata, 64'h0);
        bus_op(1'b1, 1'b1, 11'h168, 64'h1);
        chk("R10 no write strobe", {63'h0, c_wr}, 64'h0);

        // R11 status
        ch_status = 3'b101;
        bus_op(1'b0, 1'b1, 11'h020, 64'h0);
        chk("R11 status read", c_rdata, 64'h5);
        bus_op(1'b1, 1'b0, 11'h020, 64'hF);
        chk("R11 clear masked", {61'h0, c_clr}, 64'h5);
        bus_op(1'b1, 1'b0, 11'h024, 64'hF);
        chk("R11 high half clears nothing", {61'h0, c_clr}, 64'h0);
        chk("R11 idle no clear", {61'h0, status_clr}, 64'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule